// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Access

This block is a small SPI master that sits behind a 32-bit register port. It has two word registers: a control/status word and a data word. Software writes one byte to the data word. It then writes the control word with the start bit set. The block sends that byte out on `mosi`, most significant bit first, and captures one byte from `miso` at the same time. Once the busy flag in the control word drops, software reads the captured byte back from the data word.

Three chip-select outputs follow raw control bits, and software chooses their polarity. The serial clock comes from the block clock through a 5-bit divider. It supports both clock polarities and both clock phases. A loopback switch routes the outgoing bit stream back into the receiver in place of `miso`. Each control write reloads every control field at once, so software repeats the select, divider and mode fields with each start. A divider, mode or loopback change that arrives during an exchange only takes effect at the next start.

Top module: `byte_spi_master`

## Requirements
- R1: The control/status word is at byte offset 0x0 and the data word at offset 0x4. Writes to any other offset change nothing. A data-word write made while idle reads back in bits 7:0, with bits 31:8 reading zero.
- R2: A control write with bit 1 set, made while idle, starts one exchange. Bit 1 of a control read returns 1 from the next cycle on, and stays 1 for exactly 16·(N+1) cycles.
- R3: Chip-select outputs 0, 1 and 2 equal bits 0, 2 and 4 of the most recent control write, from the cycle after that write. This holds during an exchange too. Between control writes they do not change.
- R4: After reset the control word reads 0x0000_0015, all chip selects are high, `sck` is low, busy is 0 and the data word reads 0.
- R5: Control bits 31:27 hold the divider N. Each `sck` half period lasts N+1 clock cycles, and an exchange makes exactly 16 `sck` transitions.
- R6: Bit 5 (polarity) sets the `sck` level while idle. With bit 6 (phase) at 0, `mosi` holds each bit before its leading edge and `miso` is sampled on leading edges. With bit 6 at 1, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R7: Data is sent most significant bit first, with full-duplex exchange. After busy clears, the data word returns the 8 bits received.
- R8: With bit 3 (loopback) set when an exchange starts, the received byte equals the transmitted byte, whatever `miso` carries.
- R9: While busy, data-word writes and start requests are ignored. The exchange in progress keeps its byte, its length and its result.
- R10: A control read returns the stored fields at bits 0, 2, 3, 4, 5, 6 and 31:27, with busy at bit 1 and zero in every other bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the divider reference |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 3 | Byte offset of the register access |
| wr_en | input | 1 | Write strobe for `wdata` at `addr` |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | 3 | Chip-select levels |

## Verification
A start write takes effect at the clock edge that accepts it, so busy is already visible at the next falling-edge sample. It drops exactly 16·(N+1) rising edges later. The bench counts those edges with a free-running counter, and does not try to infer them from polling. Chip selects and register read-backs are due one edge after the write, and are sampled at the falling edge that follows. The bench's slave model acts on each `sck` transition as it happens. `miso` changes at least N+1 cycles before the block samples it, and `mosi` is read on the edges where the block holds it steady, so no result depends on the order of events at a clock edge.

// File: rtl/bspi_pkg.sv
// Shared field positions and types for the byte-wide SPI master.
// Assumes a 32-bit control word whose bit layout software relies on.
package bspi_pkg;
    localparam int WORD_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int DIV_W     = 5;
    localparam int DIV_LSB   = 27;
    localparam int NUM_CS    = 3;
    localparam int START_BIT = 1;
    localparam int LOOP_BIT  = 3;
    localparam int CPOL_BIT  = 5;
    localparam int CPHA_BIT  = 6;
    localparam int EDGES     = 2 * BYTE_W;
    localparam int EDGE_W    = $clog2(EDGES);

    // Mode fields kept in the control register
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             cpha;
        logic             cpol;
        logic             loop;
    } mode_t;
endpackage

// File: rtl/bspi_regs.sv
// Register file and address decode. Holds chip selects and mode fields,
// turns control writes into start requests and data writes into byte loads.
// Assumes a single access per cycle; reads are combinational.
module bspi_regs
    import bspi_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int CTRL_OFS = 0,
    parameter int DATA_OFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [WORD_W-1:0] rdata,
    output mode_t             mode,
    output logic [NUM_CS-1:0] cs,
    output logic              start,
    output logic              data_wr,
    output logic [BYTE_W-1:0] data_byte
);
    logic ctrl_sel, data_sel, ctrl_wr;
    logic unused_wbits;

    assign ctrl_sel     = (addr == ADDR_W'(CTRL_OFS));
    assign data_sel     = (addr == ADDR_W'(DATA_OFS));
    assign ctrl_wr      = wr_en & ctrl_sel;
    assign start        = ctrl_wr & wdata[START_BIT] & ~busy;
    assign data_wr      = wr_en & data_sel & ~busy;
    assign data_byte    = wdata[BYTE_W-1:0];
    assign unused_wbits = ^wdata[DIV_LSB-1:CPHA_BIT+1];

    // Store chip selects and mode fields on every control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs   <= '1;
            mode <= '0;
        end else if (ctrl_wr) begin
            for (int i = 0; i < NUM_CS; i++) cs[i] <= wdata[2*i];
            mode.div  <= wdata[DIV_LSB +: DIV_W];
            mode.cpha <= wdata[CPHA_BIT];
            mode.cpol <= wdata[CPOL_BIT];
            mode.loop <= wdata[LOOP_BIT];
        end
    end

    // Assemble read data for the addressed word
    always_comb begin
        rdata = '0;
        if (ctrl_sel) begin
            for (int i = 0; i < NUM_CS; i++) rdata[2*i] = cs[i];
            rdata[START_BIT]            = busy;
            rdata[LOOP_BIT]             = mode.loop;
            rdata[CPOL_BIT]             = mode.cpol;
            rdata[CPHA_BIT]             = mode.cpha;
            rdata[DIV_LSB +: DIV_W]     = mode.div;
        end else if (data_sel) begin
            rdata[BYTE_W-1:0] = rx_byte;
        end
    end
endmodule

// File: rtl/bspi_sck_gen.sv
// Serial clock timing. Latches the divider at start and produces one
// pulse per sck half period together with the index of that transition.
// Assumes start only arrives while idle.
module bspi_sck_gen
    import bspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              busy,
    input  logic [DIV_W-1:0]  div_in,
    output logic              edge_p,
    output logic [EDGE_W-1:0] edge_idx
);
    logic [DIV_W-1:0] cnt, div_q;

    assign edge_p = busy & (cnt == div_q);

    // Count reference cycles within a half period and transitions within a byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            div_q    <= '0;
            edge_idx <= '0;
        end else if (start) begin
            cnt      <= '0;
            div_q    <= div_in;
            edge_idx <= '0;
        end else if (edge_p) begin
            cnt      <= '0;
            edge_idx <= edge_idx + 1'b1;
        end else if (busy) begin
            cnt      <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bspi_shifter.sv
// Shift engine. Holds the byte, moves bits on sck transitions according
// to the phase latched at start, and generates busy and the sck level.
// Assumes edge_p pulses 16 times per exchange, indexed from 0.
module bspi_shifter
    import bspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mode_t             mode,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data_byte,
    input  logic              edge_p,
    input  logic [EDGE_W-1:0] edge_idx,
    input  logic              miso,
    output logic              busy,
    output logic [BYTE_W-1:0] shreg,
    output logic              sck,
    output logic              mosi
);
    logic cpha_q, cpol_q, loop_q, ph, rbit, mosi_q;
    logic sample_e, shift_e, miso_in, last_e;

    assign sample_e = edge_p & (edge_idx[0] == cpha_q);
    assign shift_e  = edge_p & (edge_idx[0] != cpha_q);
    assign last_e   = edge_p & (edge_idx == EDGE_W'(EDGES-1));
    assign miso_in  = loop_q ? mosi_q : miso;
    assign mosi     = mosi_q;
    assign sck      = busy ? (cpol_q ^ ph) : mode.cpol;

    // Track busy and latch the mode for the exchange
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cpha_q <= 1'b0;
            cpol_q <= 1'b0;
            loop_q <= 1'b0;
        end else if (start) begin
            busy   <= 1'b1;
            cpha_q <= mode.cpha;
            cpol_q <= mode.cpol;
            loop_q <= mode.loop;
        end else if (last_e) begin
            busy   <= 1'b0;
        end
    end

    // Toggle the sck phase once per half period
    always_ff @(posedge clk) begin
        if (!rst_n)      ph <= 1'b0;
        else if (start)  ph <= 1'b0;
        else if (edge_p) ph <= ~ph;
    end

    // Move data through the shift register and the output bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            rbit   <= 1'b0;
            mosi_q <= 1'b0;
        end else if (data_wr) begin
            shreg  <= data_byte;
        end else if (start) begin
            mosi_q <= shreg[BYTE_W-1];
        end else if (!cpha_q) begin
            if (sample_e) rbit <= miso_in;
            if (shift_e) begin
                shreg  <= {shreg[BYTE_W-2:0], rbit};
                mosi_q <= shreg[BYTE_W-2];
            end
        end else begin
            if (shift_e)  mosi_q <= shreg[BYTE_W-1];
            if (sample_e) shreg  <= {shreg[BYTE_W-2:0], miso_in};
        end
    end
endmodule

// File: rtl/byte_spi_master.sv
// Top of the byte-wide SPI master: register port, sck timing, shift engine.
// Assumes clk is the divider reference and reset is synchronous, active low.
module byte_spi_master
    import bspi_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata,
    output logic                sck,
    output logic                mosi,
    input  logic                miso,
    output logic [NUM_CS-1:0]   cs
);
    mode_t             mode;
    logic              start, data_wr, busy_w, edge_p, idle_cpol;
    logic [BYTE_W-1:0] data_byte, shreg;
    logic [EDGE_W-1:0] edge_idx;

    assign idle_cpol = mode.cpol;

    bspi_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .busy(busy_w), .rx_byte(shreg), .rdata(rdata), .mode(mode), .cs(cs),
        .start(start), .data_wr(data_wr), .data_byte(data_byte)
    );

    bspi_sck_gen gen_i (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_w),
        .div_in(mode.div), .edge_p(edge_p), .edge_idx(edge_idx)
    );

    bspi_shifter shf_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .data_wr(data_wr), .data_byte(data_byte), .edge_p(edge_p),
        .edge_idx(edge_idx), .miso(miso), .busy(busy_w), .shreg(shreg),
        .sck(sck), .mosi(mosi)
    );
endmodule

// File: rtl/bspi_checker.sv
// Protocol checks for byte_spi_master, attached by bind below.
// Assumes the default three-bit address with the control word at 0.
module bspi_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  addr,
    input logic        wr_en,
    input logic [31:0] wdata,
    input logic [2:0]  cs,
    input logic        sck,
    input logic        busy,
    input logic        idle_cpol
);
    logic ctrl_wr;
    assign ctrl_wr = wr_en && (addr == 3'd0);

    p_start_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata[1] && !busy) |=> busy);

    p_cs_follows_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> cs == {$past(wdata[4]), $past(wdata[2]), $past(wdata[0])});

    p_cs_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(cs));

    p_sck_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck == idle_cpol);

    p_busy_start_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(ctrl_wr && wdata[1])) |=> !busy);
endmodule

bind byte_spi_master bspi_checker chk_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .cs(cs), .sck(sck), .busy(busy_w), .idle_cpol(idle_cpol)
);

// File: tb/byte_spi_master_tb_top.sv
// Sweep bench: all modes, several dividers and byte pairs, against a slave model.
module byte_spi_master_tb_top;
    logic        clk = 0, rst_n = 0, wr_en = 0, miso = 0;
    logic [2:0]  addr = 0;
    logic [31:0] wdata = 0, rdata;
    logic        sck, mosi;
    logic [2:0]  cs;
    int          n_chk = 0, n_fail = 0, cyc = 0;
    bit          done = 0;

    // slave model state
    bit          act = 0, m_cpol = 0, m_cpha = 0;
    logic [7:0]  s_tx = 0, s_rx = 0;
    int          s_idx = 0, s_edges = 0;

    byte_spi_master dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso), .cs(cs));

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // slave: acts on every sck transition during an exchange
    always @(sck) if (act) begin
        bit lead;
        lead = (sck != m_cpol);
        s_edges++;
        if (lead == !m_cpha) s_rx = {s_rx[6:0], mosi};
        if (!m_cpha && !lead) begin
            s_idx++;
            if (s_idx < 8) miso = s_tx[7 - s_idx];
        end
        if (m_cpha && lead) begin
            if (s_idx < 8) miso = s_tx[7 - s_idx];
            s_idx++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act_v, exp_v);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0; addr = 0; wdata = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // one exchange; optional writes during busy for R9
    task automatic xfer(input bit cpol, input bit cpha, input bit lp, input int n,
                        input logic [7:0] tx, input logic [7:0] slv, input bit poke);
        logic [31:0] cw, r;
        int t0, t1;
        cw = (32'(n) << 27) | (32'(cpha) << 6) | (32'(cpol) << 5) | (32'(lp) << 3) | 32'h14;
        m_cpol = cpol; m_cpha = cpha;
        wr(3'd0, cw);
        wr(3'd4, {24'h0, tx});
        s_tx = slv; s_rx = 0; s_idx = 0; s_edges = 0; miso = slv[7]; act = 1;
        wr(3'd0, cw | 32'h2);
        t0 = cyc;
        if (poke) begin
            wr(3'd4, 32'hFF);
            wr(3'd0, cw | 32'h2);
        end
        rd(3'd0, r);
        while (r[1]) begin @(negedge clk); rd(3'd0, r); end
        t1 = cyc;
        act = 0;
        check(t1 - t0 == 16 * (n + 1), "R2 busy length", t1 - t0, 16 * (n + 1));
        check(s_edges == 16, "R5 sck transitions", s_edges, 16);
        check(s_rx == tx, "R7 slave received msb-first", s_rx, tx);
        rd(3'd4, r);
        check(r == {24'h0, (lp ? tx : slv)}, lp ? "R8 loopback data" : (poke ? "R9 ignored while busy" : "R7 received byte"),
              r, {24'h0, (lp ? tx : slv)});
        check(sck == cpol, "R6 idle sck level", sck, cpol);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        int divs[3] = '{0, 1, 3};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R4 reset state
        rd(3'd0, r); check(r == 32'h15, "R4 ctrl reset", r, 32'h15);
        check(cs == 3'b111, "R4 cs reset", cs, 3'b111);
        check(sck == 0, "R4 sck reset", sck, 0);
        rd(3'd4, r); check(r == 0, "R4 data reset", r, 0);
        // R3 every chip-select pattern
        for (int v = 0; v < 8; v++) begin
            wr(3'd0, {27'h0, v[2], 1'b0, v[1], 1'b0, v[0]});
            check(cs == v[2:0], "R3 cs levels", cs, v[2:0]);
        end
        // R10 read-back masks unused bits
        wr(3'd0, 32'hF800FFFD);
        rd(3'd0, r); check(r == 32'hF800007D, "R10 ctrl readback", r, 32'hF800007D);
        wr(3'd0, 32'h15);
        // R1 data word and unmapped offset
        wr(3'd4, 32'hDEADBEA5);
        rd(3'd4, r); check(r == 32'hA5, "R1 data word", r, 32'hA5);
        wr(3'd2, 32'h0);
        rd(3'd0, r); check(r == 32'h15, "R1 unmapped write", r, 32'h15);
        check(cs == 3'b111, "R1 unmapped cs", cs, 3'b111);
        // R5 R6 R7 sweep over modes and dividers
        for (int m = 0; m < 4; m++)
            for (int d = 0; d < 3; d++) begin
                xfer(m[0], m[1], 0, divs[d], 8'hA5 ^ 8'(m * 17 + d), 8'h3C + 8'(d * 37 + m), 0);
                xfer(m[0], m[1], 0, divs[d], 8'h80 >> d, 8'h01 << m, 0);
            end
        // R8 loopback in every mode
        for (int m = 0; m < 4; m++) xfer(m[0], m[1], 1, 1, 8'hC6 + 8'(m), 8'h00, 0);
        // R9 writes during busy
        xfer(0, 0, 0, 1, 8'h5A, 8'h96, 1);
        xfer(1, 1, 0, 2, 8'h0F, 8'hE1, 1);
        // R3 cs change while busy
        wr(3'd0, 32'h0800_0016);
        check(cs == 3'b110, "R3 cs during start", cs, 3'b110);
        wr(3'd0, 32'h0800_0001);
        check(cs == 3'b001, "R3 cs while busy", cs, 3'b001);
        repeat (40) @(negedge clk);
        finish_run();
    end
endmodule